// File: doc/BRIEF.md
# Teletext line disable mask gate

This block decides, once per video line, whether teletext may be inserted on that line. A line counter elsewhere supplies the current line number, counted the 50 Hz (PAL) way, together with a field indicator and a pulse marking the start of each line. Each field has its own teletext window, given as a first and a last line. A 16-bit veto mask, one bit per line for lines 5 through 20, can then strike individual lines out of the window. One mask bit applies to the same line number in both fields.

Six byte-wide registers hold the two mask bytes and the four window bounds. They are written and read through a simple synchronous register port. The enable output is decided only at a line-start pulse and then held for the whole line. A register write in the middle of a line therefore never changes the enable partway through that line.

Top module: `ttx_line_gate`

## Requirements
- R1: After reset, all six registers read 0 and `ttx_en_o` is 0.
- R2: A write with `reg_we_i` high stores `reg_wdata_i` at `reg_addr_i`, and it reads back on `reg_rdata_o` from the next cycle on. The address map is 0 mask low, 1 mask high, 2 odd first line, 3 odd last line, 4 even first line, 5 even last line. Addresses 6 and 7 read 0, and writes to them change no register.
- R3: On the clock edge where `line_start_i` is high, `ttx_en_o` becomes 1 only if first <= `line_i` <= last. The bounds used are those of the current field: `field_odd_i`=1 selects addresses 2 and 3, and `field_odd_i`=0 selects addresses 4 and 5. A line outside the window gives 0, whatever the mask holds.
- R4: Bit k of address 0 vetoes line 5+k, and bit k of address 1 vetoes line 13+k (k = 0..7). A set bit forces `ttx_en_o` to 0 for that line number in both fields.
- R5: Lines below 5 or above 20 are never affected by the mask.
- R6: `ttx_en_o` changes only on an edge where `line_start_i` is high. A write made in the same cycle as a line start does not affect the decision taken at that line start.
- R7: A window whose first line is greater than its last line enables no line. A window whose first and last lines are equal enables exactly that one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 10 | Current line number, PAL counting |
| field_odd_i | input | 1 | 1 for the odd field, 0 for the even field |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| ttx_en_o | output | 1 | Teletext insertion allowed on the current line |

## Verification
The bench builds the block with its default parameters: a 10-bit line number, 8-bit registers, and a mask that starts at line 5 and is 16 lines long. With these values, a sweep over lines 0 to 30 crosses both ends of the mask range and both ends of each window. The 3-bit address also reaches two addresses above the six real registers, so the writes there can be shown to have no effect. The bounds are byte-wide, so the bench can also place the windows both inside and across the mask range.

// File: rtl/ttx_gate_pkg.sv
package ttx_gate_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned NUM_BND_REG = 4;

  typedef struct packed {
    logic [REG_W-1:0] first;
    logic [REG_W-1:0] last;
  } ttx_win_t;
endpackage

// File: rtl/ttx_reg_file.sv
module ttx_reg_file
  import ttx_gate_pkg::*;
#(
  parameter int unsigned NUM_MASK_REGS = 2,
  parameter int unsigned ADDR_W        = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [REG_W-1:0]                 wdata_i,
  output logic [REG_W-1:0]                 rdata_o,
  output logic [NUM_MASK_REGS*REG_W-1:0]   mask_o,
  output ttx_win_t                         win_odd_o,
  output ttx_win_t                         win_even_o
);
  localparam int unsigned NUM_REGS = NUM_MASK_REGS + NUM_BND_REG;
  localparam int unsigned BND_BASE = NUM_MASK_REGS;

  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g)) regs_q[g] <= wdata_i;
    end
  end

  for (genvar m = 0; m < NUM_MASK_REGS; m++) begin : g_mask
    assign mask_o[m*REG_W +: REG_W] = regs_q[m];
  end

  assign win_odd_o  = '{first: regs_q[BND_BASE],   last: regs_q[BND_BASE+1]};
  assign win_even_o = '{first: regs_q[BND_BASE+2], last: regs_q[BND_BASE+3]};

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
    end
  end
endmodule

// File: rtl/ttx_window_cmp.sv
module ttx_window_cmp
  import ttx_gate_pkg::*;
#(
  parameter int unsigned LINE_W = 10
) (
  input  logic [LINE_W-1:0] line_i,
  input  ttx_win_t          win_i,
  output logic              hit_o
);
  logic [LINE_W-1:0] first_ext, last_ext;
  assign first_ext = LINE_W'(win_i.first);
  assign last_ext  = LINE_W'(win_i.last);
  // empty when first > last falls out of the two compares
  assign hit_o = (line_i >= first_ext) && (line_i <= last_ext);
endmodule

// File: rtl/ttx_mask_lookup.sv
module ttx_mask_lookup #(
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned MASK_FIRST = 5,
  parameter int unsigned MASK_LINES = 16
) (
  input  logic [LINE_W-1:0]     line_i,
  input  logic [MASK_LINES-1:0] mask_i,
  output logic                  veto_o
);
  localparam int unsigned IDX_W = (MASK_LINES > 1) ? $clog2(MASK_LINES) : 1;
  localparam logic [LINE_W-1:0] LO = LINE_W'(MASK_FIRST);
  localparam logic [LINE_W-1:0] HI = LINE_W'(MASK_FIRST + MASK_LINES - 1);

  logic              in_rng;
  logic [LINE_W-1:0] off;

  assign in_rng = (line_i >= LO) && (line_i <= HI);
  assign off    = line_i - LO;

  always_comb begin
    veto_o = 1'b0;
    for (int i = 0; i < MASK_LINES; i++) begin
      if (in_rng && off[IDX_W-1:0] == IDX_W'(i)) veto_o = mask_i[i];
    end
  end
endmodule

// File: rtl/ttx_line_gate.sv
module ttx_line_gate
  import ttx_gate_pkg::*;
#(
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned MASK_FIRST = 5,
  parameter int unsigned MASK_LINES = 16,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_odd_i,
  input  logic              line_start_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              ttx_en_o
);
  localparam int unsigned NUM_MASK_REGS = MASK_LINES / REG_W;

  logic [MASK_LINES-1:0] mask_w;
  ttx_win_t              win_w [2];
  logic [1:0]            hit_w;
  logic                  veto_w;
  logic                  en_d, en_q;

  ttx_reg_file #(
    .NUM_MASK_REGS(NUM_MASK_REGS),
    .ADDR_W       (ADDR_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .mask_o    (mask_w),
    .win_odd_o (win_w[1]),
    .win_even_o(win_w[0])
  );

  // index 1 = odd field, 0 = even field
  for (genvar f = 0; f < 2; f++) begin : g_win
    ttx_window_cmp #(.LINE_W(LINE_W)) i_cmp (
      .line_i(line_i),
      .win_i (win_w[f]),
      .hit_o (hit_w[f])
    );
  end

  ttx_mask_lookup #(
    .LINE_W    (LINE_W),
    .MASK_FIRST(MASK_FIRST),
    .MASK_LINES(MASK_LINES)
  ) i_mask (
    .line_i(line_i),
    .mask_i(mask_w),
    .veto_o(veto_w)
  );

  assign en_d = hit_w[field_odd_i] & ~veto_w;

  // decision latched per line; register contents before any same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           en_q <= 1'b0;
    else if (line_start_i) en_q <= en_d;
  end

  assign ttx_en_o = en_q;
endmodule

// File: rtl/ttx_line_gate_chk.sv
module ttx_line_gate_chk
  import ttx_gate_pkg::*;
#(
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned MASK_FIRST = 5,
  parameter int unsigned MASK_LINES = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [LINE_W-1:0]     line_i,
  input logic                  field_odd_i,
  input logic                  line_start_i,
  input logic [MASK_LINES-1:0] mask_i,
  input ttx_win_t              win_odd_i,
  input ttx_win_t              win_even_i,
  input logic                  ttx_en_o
);
  int   ln, lo_c, hi_c;
  logic in_rng_c, mbit_c, win_c, exp_c;

  always_comb begin
    ln       = int'(line_i);
    lo_c     = field_odd_i ? int'(win_odd_i.first) : int'(win_even_i.first);
    hi_c     = field_odd_i ? int'(win_odd_i.last)  : int'(win_even_i.last);
    in_rng_c = (ln >= MASK_FIRST) && (ln < MASK_FIRST + MASK_LINES);
    mbit_c   = 1'b0;
    for (int i = 0; i < MASK_LINES; i++) begin
      if (ln == MASK_FIRST + i) mbit_c = mask_i[i];
    end
    win_c    = (ln >= lo_c) && (ln <= hi_c);
    exp_c    = win_c && !(in_rng_c && mbit_c);
  end

  AST_LINE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> ttx_en_o == $past(exp_c)); // R3

  AST_MASK_VETO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && in_rng_c && mbit_c |=> !ttx_en_o); // R4

  AST_OUTSIDE_MASK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && win_c && !in_rng_c |=> ttx_en_o); // R5

  AST_HOLD_MIDLINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(ttx_en_o)); // R6

  AST_EMPTY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && (lo_c > hi_c) |=> !ttx_en_o); // R7
endmodule

bind ttx_line_gate ttx_line_gate_chk #(
  .LINE_W    (LINE_W),
  .MASK_FIRST(MASK_FIRST),
  .MASK_LINES(MASK_LINES)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_i      (line_i),
  .field_odd_i (field_odd_i),
  .line_start_i(line_start_i),
  .mask_i      (mask_w),
  .win_odd_i   (win_w[1]),
  .win_even_i  (win_w[0]),
  .ttx_en_o    (ttx_en_o)
);

// File: tb/test_ttx_line_gate.sv
`timescale 1ns/1ps
module test_ttx_line_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [9:0] line_i;
  logic       field_odd_i;
  logic       line_start_i;
  logic       reg_we_i;
  logic [2:0] reg_addr_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o;
  logic       ttx_en_o;

  ttx_line_gate i_ttx_line_gate (.*);

  always #2.5 clk_i = ~clk_i;

  // reference model
  int    m_reg [8];
  bit    m_en;
  int    n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  function automatic bit model_en(int l, bit odd);
    int  lo, hi;
    bit  veto;
    lo   = odd ? m_reg[2] : m_reg[4];
    hi   = odd ? m_reg[3] : m_reg[5];
    veto = 0;
    if (l >= 5 && l <= 12)       veto = m_reg[0][l-5];
    else if (l >= 13 && l <= 20) veto = m_reg[1][l-13];
    return (l >= lo) && (l <= hi) && !veto;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_en = 0;
    end else begin
      if (line_start_i) m_en = model_en(int'(line_i), field_odd_i);
      if (reg_we_i && reg_addr_i < 6) m_reg[reg_addr_i] = int'(reg_wdata_i);
    end
  end

  task automatic compare();
    int exp_rd;
    exp_rd = (reg_addr_i < 6) ? m_reg[reg_addr_i] : 0;
    n_vec++;
    if (ttx_en_o !== m_en) begin
      n_bad++;
      $display("FAIL %s: ttx_en_o=%0b expected %0b (line %0d odd %0b)",
               tag, ttx_en_o, m_en, line_i, field_odd_i);
    end
    n_vec++;
    if (reg_rdata_o !== 8'(exp_rd)) begin
      n_bad++;
      $display("FAIL %s: reg_rdata_o=%0h expected %0h (addr %0d)",
               tag, reg_rdata_o, exp_rd, reg_addr_i);
    end
  endtask

  // one cycle: check at negedge, then drive the next inputs
  task automatic cyc(bit we, int a, int d, bit ls, int l, bit odd);
    @(negedge clk_i);
    compare();
    reg_we_i     = we;
    reg_addr_i   = 3'(a);
    reg_wdata_i  = 8'(d);
    line_start_i = ls;
    line_i       = 10'(l);
    field_odd_i  = odd;
  endtask

  task automatic wr(int a, int d);
    cyc(1, a, d, 0, 0, 0);
  endtask

  task automatic rd(int a);
    cyc(0, a, 0, 0, 0, 0);
  endtask

  // line start followed by two mid-line cycles
  task automatic do_line(int l, bit odd);
    cyc(0, 0, 0, 1, l, odd);
    cyc(0, 0, 0, 0, l, odd);
    cyc(0, 0, 0, 0, l, odd);
  endtask

  task automatic sweep(int lo, int hi);
    for (int l = lo; l <= hi; l++) begin
      do_line(l, 1);
      do_line(l, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; reg_we_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    line_start_i = 0; line_i = 0; field_odd_i = 0;
    // R1: reset values, with stimulus active during reset
    tag = "R1";
    cyc(1, 2, 8'h55, 1, 0, 1);
    cyc(1, 3, 8'hAA, 1, 0, 0);
    @(negedge clk_i); rst_ni = 1;
    for (int a = 0; a < 8; a++) rd(a);
    // R1: reset window 0..0 opens line 0 only
    do_line(0, 1); do_line(1, 0);

    // R2: write / readback, and ignored addresses 6, 7
    tag = "R2";
    for (int a = 0; a < 6; a++) wr(a, 8'h11 * (a + 1));
    for (int a = 0; a < 8; a++) rd(a);
    wr(6, 8'hFF); wr(7, 8'hEE);
    for (int a = 0; a < 8; a++) rd(a);

    // R3: windows per field, no mask
    tag = "R3";
    wr(0, 0); wr(1, 0);
    wr(2, 7); wr(3, 18); wr(4, 10); wr(5, 22);
    sweep(0, 30);

    // R4: mask bits, lines 5, 12, 13, 15, 20
    tag = "R4";
    wr(0, 8'h81); wr(1, 8'h85);
    wr(2, 0); wr(3, 30); wr(4, 3); wr(5, 25);
    sweep(3, 24);

    // R5: full mask, wide window
    tag = "R5";
    wr(0, 8'hFF); wr(1, 8'hFF);
    wr(2, 0); wr(3, 40); wr(4, 0); wr(5, 40);
    sweep(0, 26);

    // R6: mid-line write and write in the line-start cycle
    tag = "R6";
    wr(0, 0); wr(1, 0);
    cyc(0, 0, 0, 1, 8, 1);
    cyc(1, 0, 8'h08, 0, 8, 1);   // veto line 8 mid-line
    cyc(0, 0, 0, 0, 8, 1);
    cyc(0, 0, 0, 0, 8, 1);
    do_line(8, 1);
    cyc(1, 0, 8'h00, 1, 8, 0);   // clear at line start: old mask applies
    cyc(0, 0, 0, 0, 8, 0);
    do_line(8, 0);
    cyc(1, 3, 8'h05, 1, 9, 1);   // shrink odd window in same cycle
    cyc(0, 0, 0, 0, 9, 1);
    do_line(9, 1);

    // R7: empty and single-line windows
    tag = "R7";
    wr(2, 15); wr(3, 14);
    wr(4, 11); wr(5, 11);
    sweep(9, 17);

    @(negedge clk_i); compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule